// File: doc/BRIEF.md
# Test access port with boot-programming register

This block is a serial test access port controller that follows the standard sixteen-state diagram. Its instruction register is three bits wide. One private instruction code, `100`, places a three-bit data register between the serial input and the serial output. Every other code places a one-bit bypass register there.

The three-bit data register feeds a small boot-programming buffer. Bits [2:1] of the buffer form a two-bit source select, and bit [0] is the programming enable. Boot code reads these bits after reset to pick its flow. A processor-side port also reads and writes the buffer. Both power-on reset and the Test-Logic-Reset state clear the buffer.

The processor port is synchronous to the test clock, so every state element runs on the rising edge of `tck`. The only exception is the serial output stage, which is clocked on the falling edge.

Top module: `tap_progbuf`

## Requirements
- R1: The controller steps through the standard sixteen-state diagram on each rising edge of `tck`, driven by `tms`. Holding `tms` high for five edges reaches Test-Logic-Reset from any state.
- R2: `por_n` low or `trst_n` low acts at once, without waiting for a clock. It puts the controller in Test-Logic-Reset, sets the instruction to `111` (bypass) and clears the buffer. While reset is held, `tdo` and `tdo_oe` are 0.
- R3: In Capture-IR the instruction shift register loads `001`. In Shift-IR it shifts toward bit 0, taking `tdi` into bit 2, and bit 0 is presented on `tdo`.
- R4: The active instruction changes only in Update-IR, where it takes the shifted value, and in Test-Logic-Reset, where it becomes `111`. In every other state it holds.
- R5: While the instruction is `100`, the data path is three bits long. Capture-DR loads the current buffer. Shift-DR moves the bits out least significant bit first, so a scan returns the old buffer contents.
- R6: While the instruction is `100`, Update-DR copies the three shifted bits into the buffer. `prog_src` is buffer bits [2:1] and `prog_en` is buffer bit [0].
- R7: Any instruction code other than `100` selects a one-bit bypass register. It captures 0 and delays `tdi` by one shift. Update-DR then leaves the buffer unchanged.
- R8: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 exactly during Shift-IR and Shift-DR.
- R9: `cpu_wr` high at a rising edge loads `cpu_wdata` into the buffer. `cpu_rdata` always shows the buffer.
- R10: While the controller is in Test-Logic-Reset, the buffer is forced to zero and processor writes are ignored. When a processor write and a programming Update-DR fall on the same edge, the scanned value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Optional asynchronous test reset, active low |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo` |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wdata | input | 3 | Processor write data |
| cpu_rdata | output | 3 | Buffer mirror for the processor |
| prog_src | output | 2 | Programming source select (buffer bits [2:1]) |
| prog_en | output | 1 | Programming enable (buffer bit [0]) |

## Verification
The bench runs a programming scan twice in a row and checks that the second scan returns the first scan's value. A design that captures the wrong data or shifts most significant bit first would return a scrambled value. It also schedules a processor write on the same edge as Update-DR, and writes from the processor while the controller sits in Test-Logic-Reset. A wrong priority would leave the processor value in the buffer, or let the buffer survive the reset state. Further cases cover bypass scans that must not disturb the buffer, a scan that pauses halfway, an asynchronous test reset in the middle of a shift, and a long random walk on `tms`/`tdi`. Any error in the state diagram, the capture pattern or the falling-edge output timing shows up as a cycle-level mismatch.

// File: rtl/tap_progbuf.sv
module tap_progbuf #(
  parameter int IR_W = 3,
  parameter logic [IR_W-1:0] PROG_CODE = 3'b100,
  parameter logic [IR_W-1:0] IR_CAPT   = 3'b001
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       por_n,
  input  logic       tms,
  input  logic       tdi,
  output logic       tdo,
  output logic       tdo_oe,
  input  logic       cpu_wr,
  input  logic [2:0] cpu_wdata,
  output logic [2:0] cpu_rdata,
  output logic [1:0] prog_src,
  output logic       prog_en
);
  localparam logic [IR_W-1:0] RST_CODE = '1;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PSDR, S_EX2DR, S_UPDR,
    S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PSIR, S_EX2IR, S_UPIR
  } st_t;

  st_t st, st_nx;
  logic            rst_n;
  logic [IR_W-1:0] ir, ir_sr;
  logic [2:0]      dr_sr, pbuf;
  logic            byp;
  logic            sel_prog;

  assign rst_n    = por_n & trst_n;
  assign sel_prog = (ir == PROG_CODE);

  always_comb begin
    case (st)
      S_TLR:   st_nx = tms ? S_TLR   : S_RTI;
      S_RTI:   st_nx = tms ? S_SELDR : S_RTI;
      S_SELDR: st_nx = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: st_nx = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  st_nx = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: st_nx = tms ? S_UPDR  : S_PSDR;
      S_PSDR:  st_nx = tms ? S_EX2DR : S_PSDR;
      S_EX2DR: st_nx = tms ? S_UPDR  : S_SHDR;
      S_UPDR:  st_nx = tms ? S_SELDR : S_RTI;
      S_SELIR: st_nx = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: st_nx = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  st_nx = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: st_nx = tms ? S_UPIR  : S_PSIR;
      S_PSIR:  st_nx = tms ? S_EX2IR : S_PSIR;
      S_EX2IR: st_nx = tms ? S_UPIR  : S_SHIR;
      S_UPIR:  st_nx = tms ? S_SELDR : S_RTI;
      default: st_nx = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st <= S_TLR;
    else        st <= st_nx;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ir    <= RST_CODE;
      ir_sr <= IR_CAPT;
    end else begin
      if (st == S_CAPIR)     ir_sr <= IR_CAPT;
      else if (st == S_SHIR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (st == S_TLR)       ir <= RST_CODE;
      else if (st == S_UPIR) ir <= ir_sr;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      dr_sr <= '0;
      byp   <= 1'b0;
    end else if (sel_prog) begin
      if (st == S_CAPDR)     dr_sr <= pbuf;
      else if (st == S_SHDR) dr_sr <= {tdi, dr_sr[2:1]};
    end else begin
      if (st == S_CAPDR)     byp <= 1'b0;
      else if (st == S_SHDR) byp <= tdi;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                        pbuf <= '0;
    else if (st == S_TLR)              pbuf <= '0;
    else if (st == S_UPDR && sel_prog) pbuf <= dr_sr;
    else if (cpu_wr)                   pbuf <= cpu_wdata;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (st == S_SHIR) || (st == S_SHDR);
      if (st == S_SHIR)      tdo <= ir_sr[0];
      else if (st == S_SHDR) tdo <= sel_prog ? dr_sr[0] : byp;
      else                   tdo <= 1'b0;
    end
  end

  assign cpu_rdata = pbuf;
  assign prog_src  = pbuf[2:1];
  assign prog_en   = pbuf[0];

  a_r1_selir_escape: assert property (@(posedge tck) disable iff (!rst_n)
    (st == S_SELIR && tms) |=> (st == S_TLR));
  a_r1_tlr_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (st == S_TLR && tms) |=> (st == S_TLR));
  a_r3_capture_pattern: assert property (@(posedge tck) disable iff (!rst_n)
    (st == S_CAPIR) |=> (ir_sr == IR_CAPT));
  a_r4_ir_holds: assert property (@(posedge tck) disable iff (!rst_n)
    (st != S_UPIR && st != S_TLR) |=> $stable(ir));
  a_r6_update_loads: assert property (@(posedge tck) disable iff (!rst_n)
    (st == S_UPDR && sel_prog) |=> (cpu_rdata == $past(dr_sr)));
  a_r9_cpu_write: assert property (@(posedge tck) disable iff (!rst_n)
    (cpu_wr && st != S_TLR && !(st == S_UPDR && sel_prog)) |=> (cpu_rdata == $past(cpu_wdata)));
  a_r10_tlr_clears: assert property (@(posedge tck) disable iff (!rst_n)
    (st == S_TLR) |=> (cpu_rdata == 3'b000));
  a_r8_oe_only_shift: assert property (@(posedge tck) disable iff (!rst_n)
    (st == S_RTI && $past(st) == S_RTI) |-> !tdo_oe);
endmodule

// File: tb/tap_progbuf_tb.sv
`timescale 1ns/1ps
module tap_progbuf_tb_top;
  logic tck = 0, trst_n = 1, por_n = 0, tms = 1, tdi = 0, cpu_wr = 0;
  logic [2:0] cpu_wdata = 0;
  logic tdo, tdo_oe, prog_en;
  logic [2:0] cpu_rdata;
  logic [1:0] prog_src;

  tap_progbuf dut_i (.tck(tck), .trst_n(trst_n), .por_n(por_n), .tms(tms), .tdi(tdi),
    .tdo(tdo), .tdo_oe(tdo_oe), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .prog_src(prog_src), .prog_en(prog_en));

  always #5 tck = ~tck;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";
  int m_st, m_ir, m_irsr, m_drsr, m_byp, m_buf, m_tdo, m_oe;
  logic [7:0] last_out;

  function automatic int nxt(int s, int t);
    case (s)
      0: return t ? 0 : 1;    1: return t ? 2 : 1;
      2: return t ? 9 : 3;    3: return t ? 5 : 4;
      4: return t ? 5 : 4;    5: return t ? 8 : 6;
      6: return t ? 7 : 6;    7: return t ? 8 : 4;
      8: return t ? 2 : 1;    9: return t ? 0 : 10;
      10: return t ? 12 : 11; 11: return t ? 12 : 11;
      12: return t ? 15 : 13; 13: return t ? 14 : 13;
      14: return t ? 15 : 11; default: return t ? 2 : 1;
    endcase
  endfunction

  task automatic m_reset();
    m_st = 0; m_ir = 7; m_irsr = 1; m_drsr = 0; m_byp = 0; m_buf = 0; m_tdo = 0; m_oe = 0;
  endtask

  task automatic check(string t, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    check(tag, {tdo, tdo_oe, cpu_rdata, prog_src, prog_en},
          {m_tdo[0], m_oe[0], m_buf[2:0], m_buf[2:1], m_buf[0]});
  endtask

  task automatic tick(input logic t, input logic d, input logic w = 0, input logic [2:0] wd = 0);
    int s, ir, irsr, drsr, byp, pb;
    tms = t; tdi = d; cpu_wr = w; cpu_wdata = wd;
    @(posedge tck);
    s = m_st; ir = m_ir; irsr = m_irsr; drsr = m_drsr; byp = m_byp; pb = m_buf;
    if (s == 0) begin m_ir = 7; m_buf = 0; end
    else begin
      if (s == 15) m_ir = irsr;
      if (s == 8 && ir == 4) m_buf = drsr;
      else if (w) m_buf = wd;
    end
    if (s == 10) m_irsr = 1;
    else if (s == 11) m_irsr = (d << 2) | (irsr >> 1);
    if (ir == 4) begin
      if (s == 3) m_drsr = pb;
      else if (s == 4) m_drsr = (d << 2) | (drsr >> 1);
    end else begin
      if (s == 3) m_byp = 0;
      else if (s == 4) m_byp = d;
    end
    m_st = nxt(s, t);
    #1 cmp_all(); // R8: nothing may move before the falling edge
    @(negedge tck);
    m_oe = (m_st == 11 || m_st == 4);
    m_tdo = (m_st == 11) ? (m_irsr & 1) : (m_st == 4) ? ((m_ir == 4) ? (m_drsr & 1) : m_byp) : 0;
    #1 cmp_all();
    cpu_wr = 0;
  endtask

  task automatic ir_scan(input logic [2:0] code);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin last_out[i] = tdo; tick(i == 2, code[i]); end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic dr_scan(input int n, input logic [7:0] v, input logic pause = 0,
                         input logic w = 0, input logic [2:0] wd = 0);
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      last_out[i] = tdo;
      tick((i == n - 1) || (pause && i == 0), v[i]);
      if (pause && i == 0 && n > 1) begin tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0); end
    end
    tick(1, 0); tick(0, 0, w, wd);
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_reset();
    #23;
    tag = "R2";
    check("R2 reset outputs", {tdo, tdo_oe, cpu_rdata}, 0);
    por_n = 1;
    @(negedge tck); #1;
    tag = "R1"; for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0);
    tag = "R3"; ir_scan(3'b100);
    check("R3 captured IR pattern", last_out[2:0], 3'b001);
    tag = "R6"; dr_scan(3, 8'b101);
    check("R6 source select", prog_src, 2'b10);
    check("R6 enable bit", prog_en, 1);
    tag = "R5"; dr_scan(3, 8'b010);
    check("R5 readback of previous buffer", last_out[2:0], 3'b101);
    tag = "R9"; tick(0, 0, 1, 3'b011); tick(0, 0);
    check("R9 cpu write", cpu_rdata, 3'b011);
    dr_scan(3, 8'b000);
    check("R9 cpu value seen by scan", last_out[2:0], 3'b011);
    tag = "R10"; dr_scan(3, 8'b110, 0, 1, 3'b001);
    check("R10 scan beats cpu write", cpu_rdata, 3'b110);
    tag = "R5"; dr_scan(3, 8'b001, 1);
    check("R5 paused scan readback", last_out[2:0], 3'b110);
    check("R6 paused scan update", cpu_rdata, 3'b001);
    tag = "R7"; ir_scan(3'b011);
    dr_scan(4, 8'b1011);
    check("R7 bypass output", last_out[3:0], 4'b0110);
    check("R7 buffer untouched", cpu_rdata, 3'b001);
    tag = "R4"; dr_scan(3, 8'b111);
    check("R4 instruction kept", cpu_rdata, 3'b001);
    tag = "R10"; tick(1, 0); tick(1, 0); tick(1, 0);
    tick(1, 0, 1, 3'b111); tick(1, 0, 1, 3'b111);
    check("R10 buffer cleared in reset state", cpu_rdata, 0);
    tick(0, 0);
    tag = "R4"; dr_scan(1, 8'b1);
    check("R4 reset state selects bypass", last_out[0], 0);
    tag = "R2"; ir_scan(3'b100); tick(0, 0, 1, 3'b101);
    tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);
    #2 trst_n = 0; m_reset(); #1;
    check("R2 async test reset", {tdo, tdo_oe, cpu_rdata}, 0);
    @(negedge tck); #1 trst_n = 1;
    tag = "R1";
    for (int i = 0; i < 3000; i++) tick($urandom % 3 == 0, $urandom % 2, $urandom % 7 == 0, 3'($urandom));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule